// File: doc/BRIEF.md
# Parallel LCD Write-Cycle Sequencer

This block turns each word presented on a valid/ready request port into one write cycle on an 8080-style parallel LCD bus. A request carries a register-select/address value and a data word. The block drives the address, an active-low chip select, an active-low write strobe and the data bus. Four run-time cycle counts set the timing, and each count is stretched by one cycle. The first count is the address settle time before chip select falls. The second is the gap from chip select falling to the write strobe falling. The third is how long the write strobe stays low. The fourth is the hold from the write strobe rising to chip select rising.

The four counts live in a small timing register that software loads as a group through one write strobe. Reset sets them to 0, 0, 1 and 0. When a request is accepted, the sequencer takes a private copy of the timing register. A later rewrite therefore shapes only the requests that come after it. A busy flag is high for the whole of a write cycle, and the request port is ready only while the bus is idle.

Top module: `i80WriteSeq`

## Requirements
- R1: After a synchronous active-high reset, lcdCsN and lcdWrN are 1, inReady is 1, busy is 0, and lcdAddr and lcdData are 0.
- R2: inReady is 1 exactly when no write cycle is in progress, and busy is always its inverse. A request is accepted on a rising edge where both inValid and inReady are 1.
- R3: lcdAddr takes the request's address on the acceptance edge. lcdCsN stays 1 for cs_setup+1 cycles counted from that edge, and then goes to 0.
- R4: lcdWrN goes to 0 exactly wr_setup+1 cycles after lcdCsN goes to 0.
- R5: lcdWrN stays 0 for exactly wr_active+1 cycles. lcdWrN is never 0 while lcdCsN is 1.
- R6: lcdCsN returns to 1 exactly wr_hold+1 cycles after lcdWrN returns to 1, and the cycle ends at that point.
- R7: lcdData carries the request's data word while lcdWrN is low and during the hold interval, and is 0 at all other times. lcdAddr holds its value from acceptance until the next acceptance.
- R8: Reset loads the timing register with the defaults cs_setup=0, wr_setup=0, wr_active=1 and wr_hold=0. A cycle where cfgWe is 1 loads all four 4-bit counts from the cfg inputs.
- R9: The timing is copied at acceptance. A cfgWe write during a cycle leaves that cycle unchanged and applies from the next accepted request. A write on the same edge as an acceptance applies only to later requests.
- R10: With inValid held high, the next request is accepted on the first cycle with lcdCsN high after the previous cycle. Its cs_setup interval starts on the cycle right after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Load all four timing counts |
| cfgCsSetup | input | 4 | Address-to-chip-select setup count |
| cfgWrSetup | input | 4 | Chip-select-to-strobe setup count |
| cfgWrActive | input | 4 | Strobe low width count |
| cfgWrHold | input | 4 | Strobe-to-chip-select hold count |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Request accepted when high with inValid |
| inAddr | input | AW | Request address / register select |
| inData | input | DW | Request data word |
| lcdAddr | output | AW | Bus address |
| lcdCsN | output | 1 | Chip select, active low |
| lcdWrN | output | 1 | Write strobe, active low |
| lcdData | output | DW | Bus data, zero outside the driven window |
| busy | output | 1 | Write cycle in progress |

## Verification
The assertions assume that rst is held for at least one edge before checking begins. They also assume that the request and cfg inputs stay steady around each rising edge. The bench drives every input on the falling edge and samples every output there too. It releases reset only after two edges. It then compares each cycle against a behavioural timeline built from the four counts captured at acceptance. The stimulus covers the default counts, maximum counts of 15, requests sent back to back, and timing rewrites made during a cycle and on the same edge as an acceptance.

// File: rtl/i80SeqPkg.sv
package i80SeqPkg;
  localparam int TW = 4;

  localparam logic [TW-1:0] DEF_CS_SETUP  = 4'd0;
  localparam logic [TW-1:0] DEF_WR_SETUP  = 4'd0;
  localparam logic [TW-1:0] DEF_WR_ACTIVE = 4'd1;
  localparam logic [TW-1:0] DEF_WR_HOLD   = 4'd0;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CSSET, PH_WRSET, PH_ACTIVE, PH_HOLD
  } phase_t;

  typedef struct packed {
    logic [TW-1:0] csSetup;
    logic [TW-1:0] wrSetup;
    logic [TW-1:0] wrActive;
    logic [TW-1:0] wrHold;
  } timing_t;

  typedef struct packed {
    logic accept;
    logic csLow;
    logic wrLow;
    logic dataOn;
  } seqStrobe_t;

  localparam timing_t TIMING_RESET = '{
    csSetup:  DEF_CS_SETUP,
    wrSetup:  DEF_WR_SETUP,
    wrActive: DEF_WR_ACTIVE,
    wrHold:   DEF_WR_HOLD
  };
endpackage

// File: rtl/i80SeqCtrl.sv
module i80SeqCtrl
  import i80SeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  timing_t    liveTiming,
  input  timing_t    heldTiming,
  output logic       inReady,
  output seqStrobe_t stb
);
  phase_t        phase, phaseNxt;
  logic [TW-1:0] cnt, cntNxt;

  always_comb begin
    phaseNxt = phase;
    cntNxt   = cnt;
    unique case (phase)
      PH_IDLE: if (inValid) begin
        phaseNxt = PH_CSSET;
        cntNxt   = liveTiming.csSetup;
      end
      PH_CSSET: if (cnt == '0) begin
        phaseNxt = PH_WRSET;
        cntNxt   = heldTiming.wrSetup;
      end else cntNxt = cnt - 1'b1;
      PH_WRSET: if (cnt == '0) begin
        phaseNxt = PH_ACTIVE;
        cntNxt   = heldTiming.wrActive;
      end else cntNxt = cnt - 1'b1;
      PH_ACTIVE: if (cnt == '0) begin
        phaseNxt = PH_HOLD;
        cntNxt   = heldTiming.wrHold;
      end else cntNxt = cnt - 1'b1;
      PH_HOLD: if (cnt == '0) begin
        phaseNxt = PH_IDLE;
        cntNxt   = '0;
      end else cntNxt = cnt - 1'b1;
      default: begin
        phaseNxt = PH_IDLE;
        cntNxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNxt;
      cnt   <= cntNxt;
    end
  end

  assign inReady    = (phase == PH_IDLE);
  assign stb.accept = inReady && inValid;
  assign stb.csLow  = (phase == PH_WRSET) || (phase == PH_ACTIVE) || (phase == PH_HOLD);
  assign stb.wrLow  = (phase == PH_ACTIVE);
  assign stb.dataOn = (phase == PH_ACTIVE) || (phase == PH_HOLD);

  // R3: chip select only falls out of the address setup interval
  assert_cs_fall_after_setup_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(stb.csLow) |-> $past(phase) == PH_CSSET);
  // R4: strobe only falls out of the chip-select setup interval
  assert_wr_fall_after_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(stb.wrLow) |-> $past(phase) == PH_WRSET);
  // R5: active width counter never exceeds the captured count
  assert_active_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACTIVE) |-> cnt <= heldTiming.wrActive);
  // R6: chip select releases only from the hold interval
  assert_cs_rise_after_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(stb.csLow) |-> $past(phase) == PH_HOLD);
  // R2: acceptance always starts the address setup interval
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (rst)
    stb.accept |=> phase == PH_CSSET);
endmodule

// File: rtl/i80SeqPath.sv
module i80SeqPath
  import i80SeqPkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  seqStrobe_t    stb,
  input  logic          cfgWe,
  input  timing_t       cfgIn,
  input  logic [AW-1:0] inAddr,
  input  logic [DW-1:0] inData,
  output timing_t       liveTiming,
  output timing_t       heldTiming,
  output logic [AW-1:0] lcdAddr,
  output logic          lcdCsN,
  output logic          lcdWrN,
  output logic [DW-1:0] lcdData
);
  logic [AW-1:0] addrReg;
  logic [DW-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      liveTiming <= TIMING_RESET;
      heldTiming <= TIMING_RESET;
      addrReg    <= '0;
      dataReg    <= '0;
    end else begin
      if (cfgWe) liveTiming <= cfgIn;
      if (stb.accept) begin
        heldTiming <= liveTiming;
        addrReg    <= inAddr;
        dataReg    <= inData;
      end
    end
  end

  assign lcdAddr = addrReg;
  assign lcdCsN  = ~stb.csLow;
  assign lcdWrN  = ~stb.wrLow;
  assign lcdData = stb.dataOn ? dataReg : '0;

  // R5: strobe low only inside chip select
  assert_wr_inside_cs_R5: assert property (@(posedge clk) disable iff (rst)
    !lcdWrN |-> !lcdCsN);
  // R7: data window lies inside chip select
  assert_data_inside_cs_R7: assert property (@(posedge clk) disable iff (rst)
    stb.dataOn |-> stb.csLow);
  // R9: captured timing stays fixed while a cycle runs
  assert_timing_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (stb.csLow && !stb.accept) |=> $stable(heldTiming));
endmodule

// File: rtl/i80WriteSeq.sv
module i80WriteSeq
  import i80SeqPkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfgWe,
  input  logic [3:0]    cfgCsSetup,
  input  logic [3:0]    cfgWrSetup,
  input  logic [3:0]    cfgWrActive,
  input  logic [3:0]    cfgWrHold,
  input  logic          inValid,
  output logic          inReady,
  input  logic [AW-1:0] inAddr,
  input  logic [DW-1:0] inData,
  output logic [AW-1:0] lcdAddr,
  output logic          lcdCsN,
  output logic          lcdWrN,
  output logic [DW-1:0] lcdData,
  output logic          busy
);
  seqStrobe_t stb;
  timing_t    liveTiming, heldTiming, cfgIn;

  assign cfgIn = '{csSetup: cfgCsSetup, wrSetup: cfgWrSetup,
                   wrActive: cfgWrActive, wrHold: cfgWrHold};

  i80SeqCtrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .liveTiming(liveTiming), .heldTiming(heldTiming),
    .inReady(inReady), .stb(stb)
  );

  i80SeqPath #(.AW(AW), .DW(DW)) uPath (
    .clk(clk), .rst(rst), .stb(stb), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .inAddr(inAddr), .inData(inData),
    .liveTiming(liveTiming), .heldTiming(heldTiming),
    .lcdAddr(lcdAddr), .lcdCsN(lcdCsN), .lcdWrN(lcdWrN), .lcdData(lcdData)
  );

  assign busy = ~inReady;

  // R2: ready only while the bus is fully released
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    inReady |-> (lcdCsN && lcdWrN));
endmodule

// File: tb/sim_i80WriteSeq.sv
module sim_i80WriteSeq;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 0, rst = 1;
  logic cfgWe = 0;
  logic [3:0] cfgCsSetup = 0, cfgWrSetup = 0, cfgWrActive = 0, cfgWrHold = 0;
  logic inValid = 0;
  logic [AW-1:0] inAddr = 0;
  logic [DW-1:0] inData = 0;
  logic inReady, lcdCsN, lcdWrN, busy;
  logic [AW-1:0] lcdAddr;
  logic [DW-1:0] lcdData;

  int errors = 0, checks = 0, cyc = 0;
  string scen = "R1";

  always #4 clk = ~clk;

  i80WriteSeq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgCsSetup(cfgCsSetup),
    .cfgWrSetup(cfgWrSetup), .cfgWrActive(cfgWrActive), .cfgWrHold(cfgWrHold),
    .inValid(inValid), .inReady(inReady), .inAddr(inAddr), .inData(inData),
    .lcdAddr(lcdAddr), .lcdCsN(lcdCsN), .lcdWrN(lcdWrN), .lcdData(lcdData),
    .busy(busy)
  );

  // Behavioural reference: a timeline built from the counts captured at acceptance
  bit mBusy = 0;
  int t = 0, dA = 0, dB = 0, dC = 0, dD = 0;
  int cCs = 0, cWs = 0, cAc = 1, cHo = 0;
  logic [AW-1:0] mAddr = 0;
  logic [DW-1:0] mData = 0;

  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; t = 0; mAddr = 0; mData = 0;
      cCs = 0; cWs = 0; cAc = 1; cHo = 0;
    end else begin
      if (mBusy) begin
        t++;
        if (t == dD) mBusy = 0;
      end else if (inValid) begin
        mBusy = 1; t = 0;
        dA = cCs + 1; dB = dA + cWs + 1; dC = dB + cAc + 1; dD = dC + cHo + 1;
        mAddr = inAddr; mData = inData;
      end
      if (cfgWe) begin
        cCs = cfgCsSetup; cWs = cfgWrSetup; cAc = cfgWrActive; cHo = cfgWrHold;
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      chk("R2 ready", inReady, !mBusy);
      chk("R2 busy", busy, mBusy);
      chk("R3 csN", lcdCsN, !(mBusy && t >= dA));
      chk("R5 wrN", lcdWrN, !(mBusy && t >= dB && t < dC));
      chk("R7 data", lcdData, (mBusy && t >= dB) ? mData : 0);
      chk("R7 addr", lcdAddr, mAddr);
    end
  end

  task automatic send(logic [AW-1:0] a, logic [DW-1:0] d);
    bit acc;
    inAddr = a; inData = d; inValid = 1;
    do begin
      acc = inReady;
      @(negedge clk);
    end while (!acc);
    inValid = 0;
  endtask

  task automatic setCfg(int cs, int ws, int ac, int ho);
    cfgCsSetup = 4'(cs); cfgWrSetup = 4'(ws); cfgWrActive = 4'(ac); cfgWrHold = 4'(ho);
    cfgWe = 1;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic waitIdle();
    while (!inReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    // R1: reset state before any request
    chk("R1 csN", lcdCsN, 1);
    chk("R1 wrN", lcdWrN, 1);
    chk("R1 ready", inReady, 1);
    chk("R1 busy", busy, 0);
    chk("R1 data", lcdData, 0);
    chk("R1 addr", lcdAddr, 0);
    @(negedge clk);

    scen = "R8 defaults";
    send(8'h11, 16'hA001); waitIdle();

    scen = "R4 wr_setup";
    setCfg(2, 3, 0, 1);
    send(8'h22, 16'hB002); waitIdle();

    scen = "R6 hold";
    setCfg(0, 1, 2, 5);
    send(8'h33, 16'hC003); waitIdle();

    scen = "R5 max counts";
    setCfg(15, 15, 15, 15);
    send(8'hFF, 16'hFFFF); waitIdle();

    scen = "R10 back to back";
    setCfg(1, 0, 1, 0);
    send(8'h40, 16'h1234);
    send(8'h41, 16'h5678);
    send(8'h42, 16'h9ABC);
    waitIdle();

    scen = "R9 mid-cycle rewrite";
    setCfg(3, 1, 2, 1);
    send(8'h50, 16'h0F0F);
    setCfg(0, 0, 0, 0);
    waitIdle();
    send(8'h51, 16'hF0F0); waitIdle();

    scen = "R9 same-edge rewrite";
    setCfg(2, 2, 2, 2);
    cfgCsSetup = 4'd6; cfgWrSetup = 4'd0; cfgWrActive = 4'd4; cfgWrHold = 4'd3;
    cfgWe = 1;
    send(8'h60, 16'h6666);
    cfgWe = 0;
    waitIdle();
    send(8'h61, 16'h7777); waitIdle();

    scen = "R8 reset restores defaults";
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    send(8'h70, 16'h7070); waitIdle();

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule